// File: doc/BRIEF.md
# Four-Lane Receive Deskew and Ten-Lane Row Rebuild

This block sits on the receive side of a link where a ten-lane striped stream of 66-bit blocks is carried over four physical lanes. On the wire, the stream is a repeating period of `PERIOD_ROWS` rows, and each row holds ten blocks. The first row of every period is an alignment row made of ten marker blocks, with indices 0 to 9 in order. The remaining rows carry data. Stream blocks are dealt round-robin onto the four lanes. Because ten is not a multiple of four, an alignment row starts either on lane 0 or on lane 2. The receiver has to tell these two layouts apart.

Each lane hunts for the first marker whose index is 0 to 3. From that block onward, the lane writes everything it receives into its own FIFO. The FIFOs absorb the relative skew between lanes. Reading starts once all four lanes have captured a marker. At that point the marker index seen on lane 0 selects the layout, and with it the lane at which the stream order begins. The four FIFO heads are read together as four consecutive stream blocks. The block checks the marker positions, drops the alignment row and regroups the data blocks into complete ten-block rows. `locked` rises once two consecutive alignment rows have been confirmed. A FIFO overflow, a missing marker or a misplaced marker clears `locked`, flushes the path and starts a fresh hunt.

Top module: `lane4_deskew`

## Requirements
- R1: A marker block has bits [65:64]=2'b10, bits [63:56] equal to `MARK_TYPE`, and its index in bits [55:52]. A lane captures only a marker whose index is 0 to 3. A block with the marker sync but another type byte is ignored as a marker.
- R2: If lane 0's first captured index is 0, the layout is A and `layout_b`=0. If it is 2, the layout is B and `layout_b`=1. In both cases the rows come out in original stream order.
- R3: Skew of up to `FIFO_DEPTH`-1 cycles between any lanes produces exactly the same output rows as zero skew. No FIFO is read before all four lanes have captured a marker.
- R4: Skew of `FIFO_DEPTH` cycles or more overflows a FIFO. Such a stream never sets `locked` and produces no rows.
- R5: Each output row is ten consecutive data blocks of the stream. Row lane k is at `out_row` bits [66k+65:66k]. `out_valid` is high for exactly one cycle per row.
- R6: Alignment rows are removed. No marker block ever appears in an output row.
- R7: `locked` rises on the second consecutive confirmed alignment row. Exactly `PERIOD_ROWS`-1 data rows come out before it.
- R8: A marker that is missing, or that carries the wrong index at an expected position, clears `locked`. The block then resynchronises and locks again after two more good alignment rows.
- R9: After reset, `out_valid`, `locked` and `layout_b` are 0.
- R10: Cycles with `in_valid` low stall all lanes together and lose no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | All four lane blocks are valid this cycle |
| in_blks | input | 264 | Lane l block at bits [66l+65:66l] |
| out_valid | output | 1 | Pulses once per rebuilt row |
| out_row | output | 660 | Ten rebuilt blocks, row lane k at [66k+65:66k] |
| locked | output | 1 | Alignment confirmed on two consecutive rows |
| layout_b | output | 1 | 1 when alignment rows start on lane 2 |

## Verification
The assertions check several rules on every cycle. An overflow or a marker error is always followed by `locked` low. `locked` rises only on a confirmed alignment row. An output row always follows a FIFO read, and that row never holds a marker. FIFO reads happen only with all lanes captured. Other properties span whole streams, and only the bench scenarios can show them. These are the ordering of rebuilt rows in each layout, the exact skew boundary at the FIFO depth, and the count of rows before lock. They also include recovery after a corrupted marker and the effect of a rejected type byte on where the hunt restarts.

// File: rtl/l4d_pkg.sv
package l4d_pkg;
  localparam int BLK_W     = 66;
  localparam int ROW_LANES = 10;
  localparam int PHY_LANES = 4;

  typedef logic [BLK_W-1:0] blk_t;

  // sync header plus type byte identify an alignment block
  function automatic logic is_mark(input logic [1:0] sync, input logic [7:0] typ,
                                   input logic [7:0] mtype);
    return (sync == 2'b10) && (typ == mtype);
  endfunction

  // stream position advanced by step, wrapped at the period length
  function automatic int wrap_pos(input int pos, input int step, input int period);
    int s;
    s = pos + step;
    if (s >= period) s = s - period;
    return s;
  endfunction

  // lane that holds stream order start, from lane 0's first marker index
  function automatic logic [1:0] rot_of(input logic [3:0] idx0);
    return idx0[1] ? 2'd2 : 2'd0;
  endfunction
endpackage

// File: rtl/l4d_lane_fifo.sv
module l4d_lane_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 66
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_rd   = rd_en && !empty;
  assign do_wr   = wr_en && (!full || do_rd);
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= bump(wp);
      if (do_rd) rp <= bump(rp);
      if (do_wr && !do_rd)      cnt <= cnt + CW'(1);
      else if (do_rd && !do_wr) cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/l4d_row_build.sv
module l4d_row_build #(
  parameter int W     = 66,
  parameter int IN_N  = 4,
  parameter int OUT_N = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_en,
  input  logic [IN_N-1:0]   keep,
  input  logic [IN_N*W-1:0] in_blks,
  output logic              row_valid,
  output logic [OUT_N*W-1:0] row
);
  localparam int BUF_N = OUT_N + IN_N;
  localparam int CW    = $clog2(BUF_N + 1);

  logic [W-1:0]  held [OUT_N];
  logic [W-1:0]  nxt  [OUT_N];
  logic [W-1:0]  tmp  [BUF_N];
  logic [CW-1:0] held_n, nn, nxt_n;
  logic          emit;

  always_comb begin
    for (int j = 0; j < OUT_N; j++) tmp[j] = held[j];
    for (int j = OUT_N; j < BUF_N; j++) tmp[j] = '0;
    nn = held_n;
    for (int i = 0; i < IN_N; i++) begin
      if (in_en && keep[i]) begin
        tmp[nn] = in_blks[i*W +: W];
        nn      = nn + CW'(1);
      end
    end
    emit  = (nn >= CW'(OUT_N));
    nxt_n = emit ? nn - CW'(OUT_N) : nn;
    for (int j = 0; j < OUT_N; j++) begin
      if (!emit)                nxt[j] = tmp[j];
      else if (j + OUT_N < BUF_N) nxt[j] = tmp[j + OUT_N];
      else                      nxt[j] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      held_n    <= '0;
      row_valid <= 1'b0;
      for (int j = 0; j < OUT_N; j++) held[j] <= '0;
    end else begin
      held_n    <= nxt_n;
      row_valid <= emit;
      for (int j = 0; j < OUT_N; j++) held[j] <= nxt[j];
      if (emit)
        for (int j = 0; j < OUT_N; j++) row[j*W +: W] <= tmp[j];
    end
  end
endmodule

// File: rtl/lane4_deskew.sv
module lane4_deskew
  import l4d_pkg::*;
#(
  parameter int         FIFO_DEPTH  = 8,
  parameter int         PERIOD_ROWS = 8,
  parameter logic [7:0] MARK_TYPE   = 8'hB4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [PHY_LANES*BLK_W-1:0]     in_blks,
  output logic                           out_valid,
  output logic [ROW_LANES*BLK_W-1:0]     out_row,
  output logic                           locked,
  output logic                           layout_b
);
  localparam int PERIOD_BLKS = PERIOD_ROWS * ROW_LANES;
  localparam int PW          = $clog2(PERIOD_BLKS);

  logic [PHY_LANES-1:0] cap_q, hunt_hit, wr_en, f_empty, f_full;
  logic [PHY_LANES-1:0] exp_mark, ok_mark, last_mark;
  blk_t                 f_out [PHY_LANES];
  blk_t                 s_blk [PHY_LANES];
  logic [PHY_LANES*BLK_W-1:0] bld_in;
  logic [3:0]           idx0_q;
  logic [PW-1:0]        pos_q;
  logic [1:0]           good_q;
  logic                 flush_q, all_cap, rd_go, lay_err;
  logic                 ovf_evt, mark_err, row_ok, resync;
  logic [1:0]           rot;

  // per-lane hunt and skew buffer
  for (genvar l = 0; l < PHY_LANES; l++) begin : g_lane
    blk_t lb;
    assign lb          = in_blks[l*BLK_W +: BLK_W];
    assign hunt_hit[l] = in_valid && !cap_q[l] && !flush_q
                         && is_mark(lb[65:64], lb[63:56], MARK_TYPE) && (lb[55:52] < 4'd4);
    assign wr_en[l]    = !flush_q && in_valid && (cap_q[l] || hunt_hit[l]);

    l4d_lane_fifo #(.DEPTH(FIFO_DEPTH), .W(BLK_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(flush_q),
      .wr_en(wr_en[l]), .rd_en(rd_go), .wr_data(lb),
      .rd_data(f_out[l]), .empty(f_empty[l]), .full(f_full[l])
    );
  end

  assign all_cap = &cap_q;
  assign rd_go   = all_cap && !(|f_empty) && !flush_q;
  assign rot     = rot_of(idx0_q);
  assign lay_err = rd_go && idx0_q[0];

  // stream-ordered view of the FIFO heads and marker position checks
  always_comb begin
    int p;
    for (int i = 0; i < PHY_LANES; i++) begin
      s_blk[i]  = f_out[rot + 2'(i)];
      p         = wrap_pos(int'(pos_q), i, PERIOD_BLKS);
      exp_mark[i]  = (p < ROW_LANES);
      last_mark[i] = (p == ROW_LANES - 1);
      ok_mark[i]   = is_mark(s_blk[i][65:64], s_blk[i][63:56], MARK_TYPE)
                     && (s_blk[i][55:52] == 4'(p));
      bld_in[i*BLK_W +: BLK_W] = s_blk[i];
    end
  end

  assign mark_err = rd_go && |(exp_mark & ~ok_mark);
  assign row_ok   = rd_go && !mark_err && !lay_err && |last_mark;
  assign ovf_evt  = |(wr_en & f_full) && !rd_go;
  assign resync   = ovf_evt || mark_err || lay_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q   <= '0;
      idx0_q  <= '0;
      pos_q   <= '0;
      good_q  <= '0;
      locked  <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= resync;
      if (flush_q) begin
        cap_q  <= '0;
        idx0_q <= '0;
        pos_q  <= '0;
        good_q <= '0;
        locked <= 1'b0;
      end else if (resync) begin
        good_q <= '0;
        locked <= 1'b0;
      end else begin
        cap_q <= cap_q | hunt_hit;
        if (hunt_hit[0]) idx0_q <= in_blks[55:52];
        if (rd_go) pos_q <= PW'(wrap_pos(int'(pos_q), PHY_LANES, PERIOD_BLKS));
        if (row_ok) begin
          if (good_q != 2'd2) good_q <= good_q + 2'd1;
          if (good_q != 2'd0) locked <= 1'b1;
        end
      end
    end
  end

  assign layout_b = idx0_q[1];

  l4d_row_build #(.W(BLK_W), .IN_N(PHY_LANES), .OUT_N(ROW_LANES)) u_build (
    .clk(clk), .rst_n(rst_n), .flush(flush_q),
    .in_en(rd_go && !resync), .keep(~exp_mark), .in_blks(bld_in),
    .row_valid(out_valid), .row(out_row)
  );
endmodule

// File: rtl/lane4_deskew_chk.sv
module lane4_deskew_chk
  import l4d_pkg::*;
#(
  parameter logic [7:0] MARK_TYPE = 8'hB4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       out_valid,
  input logic [ROW_LANES*BLK_W-1:0] out_row,
  input logic                       locked,
  input logic                       ovf_evt,
  input logic                       mark_err,
  input logic                       row_ok,
  input logic                       rd_go,
  input logic                       all_cap
);
  logic row_has_mark;

  always_comb begin
    row_has_mark = 1'b0;
    for (int j = 0; j < ROW_LANES; j++)
      if (is_mark(out_row[j*BLK_W+64 +: 2], out_row[j*BLK_W+56 +: 8], MARK_TYPE))
        row_has_mark = 1'b1;
  end

  // R4
  overflow_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> !locked);

  // R8
  marker_err_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_err |=> !locked);

  // R7
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(row_ok));

  // R6
  no_marker_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !row_has_mark);

  // R5
  row_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(rd_go));

  // R3
  read_all_captured_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> all_cap);
endmodule

bind lane4_deskew lane4_deskew_chk #(.MARK_TYPE(MARK_TYPE)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_row(out_row),
  .locked(locked), .ovf_evt(ovf_evt), .mark_err(mark_err), .row_ok(row_ok),
  .rd_go(rd_go), .all_cap(all_cap)
);

// File: tb/test_lane4_deskew.sv
module test_lane4_deskew;
  localparam int DEPTH = 8;
  localparam int PR    = 8;
  localparam int PB    = PR * 10;
  localparam int CPP   = PB / 4;
  localparam logic [7:0] MT = 8'hB4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [263:0] lanes_in = '0;
  logic         out_valid, locked, layout_b;
  logic [659:0] out_row;

  lane4_deskew #(.FIFO_DEPTH(DEPTH), .PERIOD_ROWS(PR), .MARK_TYPE(MT)) i_lane4_deskew (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_blks(lanes_in),
    .out_valid(out_valid), .out_row(out_row), .locked(locked), .layout_b(layout_b)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  int skew [4];
  int shift = 0, nblk = 0, corrupt_b = -1, corrupt_kind = 0;
  int rows_n = 0, rows_before_lock = 0, first_b0 = -1, exp_b0 = 0;
  bit seq_on = 1, lock_seen = 0, lock_fell = 0, prev_locked = 0, done = 0;
  logic mid_locked = 0, mid_layout = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [65:0] mk(input int b);
    int q, idx;
    logic [7:0] typ;
    if (b < 0 || b >= nblk) return {2'b01, 32'hF1110000, 32'h0};
    q = b % PB;
    if (q < 10) begin
      typ = MT; idx = q;
      if (b == corrupt_b && corrupt_kind == 1) typ = 8'h00;
      if (b == corrupt_b && corrupt_kind == 2) idx = q ^ 1;
      return {2'b10, typ, 4'(idx), 52'h0};
    end
    return {2'b01, 32'hDA7A0000, 32'(b)};
  endfunction

  function automatic logic [65:0] lane_blk(input int l, input int t);
    if (t < skew[l]) return mk(-1);
    return mk(4 * (t - skew[l]) + l - shift);
  endfunction

  // row monitor: R5 contiguity and order, R6 no markers
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        int b0;
        bit cont, has_mark;
        b0 = int'(out_row[31:0]);
        cont = ((b0 % PB) >= 10) && (((b0 % PB) % 10) == 0);
        has_mark = 0;
        for (int j = 0; j < 10; j++) begin
          logic [65:0] bk;
          bk = out_row[j*66 +: 66];
          if (bk[65:64] == 2'b10 && bk[63:56] == MT) has_mark = 1;
          if (bk != {2'b01, 32'hDA7A0000, 32'(b0 + j)}) cont = 0;
        end
        chk(cont, "R5 row content", b0, b0);
        chk(!has_mark, "R6 marker in row", int'(has_mark), 0);
        if (rows_n == 0) first_b0 = b0;
        else if (seq_on) chk(b0 == exp_b0, "R5 row order", b0, exp_b0);
        exp_b0 = b0 + 10;
        if (exp_b0 % PB == 0) exp_b0 = exp_b0 + 10;
        if (!lock_seen && !locked) rows_before_lock++;
        rows_n++;
      end
      if (locked && !prev_locked) lock_seen = 1;
      if (!locked && prev_locked) lock_fell = 1;
      prev_locked = locked;
    end else prev_locked = 0;
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  task automatic do_reset(input int s0, input int s1, input int s2, input int s3,
                          input int sh, input int cb, input int ck);
    @(negedge clk);
    rst_n = 0; in_valid = 0;
    skew[0] = s0; skew[1] = s1; skew[2] = s2; skew[3] = s3;
    shift = sh; corrupt_b = cb; corrupt_kind = ck;
    rows_n = 0; rows_before_lock = 0; first_b0 = -1; seq_on = 1;
    lock_seen = 0; lock_fell = 0; mid_locked = 0; mid_layout = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run(input int periods, input int gap);
    int t;
    t = 0;
    nblk = periods * PB;
    for (int k = 0; k < periods * CPP + 40; k++) begin
      @(negedge clk);
      if (gap > 0 && (k % gap) == gap - 1) in_valid = 0;
      else begin
        in_valid = 1;
        for (int l = 0; l < 4; l++) lanes_in[l*66 +: 66] = lane_blk(l, t);
        t++;
        if (t == periods * CPP - 5) begin mid_locked = locked; mid_layout = layout_b; end
      end
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_reset();
    do_reset(0, 0, 0, 0, 0, -1, 0);
    @(negedge clk);
    chk(out_valid == 0, "R9 out_valid", int'(out_valid), 0);
    chk(locked == 0, "R9 locked", int'(locked), 0);
    chk(layout_b == 0, "R9 layout_b", int'(layout_b), 0);
  endtask

  task automatic t_layout_a();
    do_reset(0, 3, 1, 5, 0, -1, 0);
    run(6, 0);
    chk(rows_n == 6 * (PR - 1), "R2 layout A rows", rows_n, 6 * (PR - 1));
    chk(first_b0 == 10, "R2 layout A first row", first_b0, 10);
    chk(mid_layout == 0, "R2 layout_b A", int'(mid_layout), 0);
    chk(mid_locked == 1, "R7 locked A", int'(mid_locked), 1);
    chk(rows_before_lock == PR - 1, "R7 rows before lock", rows_before_lock, PR - 1);
  endtask

  task automatic t_layout_b_gaps();
    do_reset(2, 0, 4, 1, 2, -1, 0);
    run(6, 5);
    chk(rows_n == 6 * (PR - 1), "R10 layout B rows with gaps", rows_n, 6 * (PR - 1));
    chk(first_b0 == 10, "R2 layout B first row", first_b0, 10);
    chk(mid_layout == 1, "R2 layout_b B", int'(mid_layout), 1);
    chk(mid_locked == 1, "R10 locked with gaps", int'(mid_locked), 1);
  endtask

  task automatic t_max_skew();
    do_reset(DEPTH - 1, 0, 0, 0, 0, -1, 0);
    run(5, 0);
    chk(rows_n == 5 * (PR - 1), "R3 max skew rows", rows_n, 5 * (PR - 1));
    chk(mid_locked == 1, "R3 max skew locked", int'(mid_locked), 1);
    do_reset(0, 0, 0, DEPTH - 1, 2, -1, 0);
    run(5, 0);
    chk(rows_n == 5 * (PR - 1), "R3 max skew rows B", rows_n, 5 * (PR - 1));
  endtask

  task automatic t_overflow();
    do_reset(0, 0, 0, DEPTH, 0, -1, 0);
    run(5, 0);
    chk(rows_n == 0, "R4 overflow rows", rows_n, 0);
    chk(lock_seen == 0, "R4 overflow lock", int'(lock_seen), 0);
  endtask

  task automatic t_bad_type();
    do_reset(0, 0, 0, 0, 0, 0, 1);
    run(5, 0);
    chk(first_b0 == PB + 10, "R1 hunt skips bad type", first_b0, PB + 10);
    chk(rows_n == 4 * (PR - 1), "R1 rows after late capture", rows_n, 4 * (PR - 1));
    chk(mid_locked == 1, "R1 locked later", int'(mid_locked), 1);
  endtask

  task automatic t_corrupt(input int kind, input int a_idx);
    do_reset(1, 0, 2, 0, 0, 3 * PB + a_idx, kind);
    seq_on = 0;
    run(7, 0);
    chk(lock_fell == 1, "R8 lock cleared", int'(lock_fell), 1);
    chk(mid_locked == 1, "R8 relocked", int'(mid_locked), 1);
    chk(rows_n >= 4 * (PR - 1), "R8 rows resume", rows_n, 4 * (PR - 1));
  endtask

  initial begin
    for (int l = 0; l < 4; l++) skew[l] = 0;
    t_reset();
    t_layout_a();
    t_layout_b_gaps();
    t_max_skew();
    t_overflow();
    t_bad_type();
    t_corrupt(1, 5);   // missing marker
    t_corrupt(2, 6);   // misplaced marker index
    summary();
  end
endmodule